// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog peripheral with one 16-bit control register on a simple register bus: a select, a write enable, write data and registered read data. An internal counter advances on every clock. If software does not clear it in time, the block raises a one-cycle reset request, which the chip's reset generator turns into a system reset. Software can clear the counter, freeze it, choose one of four timeout intervals, or switch the block to interval-timer mode. In that mode a timeout raises a one-cycle interval tick instead of a reset request.

A write is accepted only when it carries a fixed key in its upper byte. A write with any other upper byte is treated as a runaway-software symptom and raises a reset request at once. Reads return a different fixed key in the upper byte, so a value read back and written again as it stands is always rejected. Two control bits for an external interrupt pin and one clock-select bit are stored and read back but do nothing here. The block runs on a single clock. Out of reset it is already counting in watchdog mode with the longest interval, so software must act within 32768 cycles.

Top module: `pwd_watchdog`

## Requirements
- R1: After the synchronous reset, `rst_req` and `ivl_tick` are 0, the counter is 0 and every control field is 0, so a read returns 16'h6900.
- R2: With no write after reset, `rst_req` first goes high in the cycle after the 32768th clock edge that follows the reset, and the count then restarts from 0.
- R3: A read (`bus_sel`=1, `bus_we`=0) presents {8'h69, control byte} on `bus_rdata` after the next clock edge. The control byte layout is: hold in bit 7, edge select in bit 6, pin enable in bit 5, interval mode in bit 4, clear in bit 3 (always read as 0), clock select in bit 2 and interval code in bits 1:0. `bus_rdata` is 0 in any cycle that follows a cycle without a read.
- R4: A write whose bits 15:8 differ from 8'h5A raises `rst_req` after that clock edge and leaves the control fields unchanged.
- R5: While hold (bit 7) is 1 the counter does not advance and no timeout occurs. After hold is written back to 0, counting resumes from the held value.
- R6: A keyed write with bit 3 set sets the count to 0 at that edge. This takes priority over both the increment and a timeout that would have fallen on the same edge.
- R7: The interval code in bits 1:0 selects a timeout after 32768, 8192, 512 or 64 counting edges for codes 00, 01, 10 and 11. A timeout occurs on the first counting edge at which the count is at or above the new terminal count minus one.
- R8: With interval mode (bit 4) set, a timeout pulses `ivl_tick` for one cycle, restarts the count and raises no `rst_req`.
- R9: Bits 6, 5 and 2 are stored and read back but do not change the counting or the outputs.
- R10: Each timeout or rejected write gives a `rst_req` pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the counter and the register |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 16 | Write data, key in bits 15:8 |
| bus_rdata | output | 16 | Registered read data |
| rst_req | output | 1 | One-cycle system reset request |
| ivl_tick | output | 1 | One-cycle interval-mode timeout tick |

## Verification
A wrong count or a wrong interval code stays hidden until the next timeout. It then shows as a `rst_req` or `ivl_tick` pulse on the wrong cycle, up to 32768 cycles late or early, so the bench measures the distance between a clearing write and the pulse at the shortest interval and once at the full reset interval. A corrupted control bit shows one cycle after any read, and a lost key check shows one cycle after a bad write. A behavioural model compares all three outputs on every cycle, so a divergence is reported at the cycle it appears.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int REG_W = 16;
  localparam int KEY_W = 8;

  localparam int B_HOLD = 7;
  localparam int B_EDGE = 6;
  localparam int B_PEN  = 5;
  localparam int B_MODE = 4;
  localparam int B_CLR  = 3;
  localparam int B_CSEL = 2;

  typedef struct packed {
    logic       hold;
    logic       edge_sel;
    logic       pin_en;
    logic       itv_mode;
    logic       clk_sel;
    logic [1:0] isel;
  } wdt_ctrl_t;

  function automatic logic [7:0] ctrl_to_byte(input wdt_ctrl_t c);
    logic [7:0] b;
    b         = '0;
    b[B_HOLD] = c.hold;
    b[B_EDGE] = c.edge_sel;
    b[B_PEN]  = c.pin_en;
    b[B_MODE] = c.itv_mode;
    b[B_CSEL] = c.clk_sel;
    b[1:0]    = c.isel;
    return b;
  endfunction

  function automatic wdt_ctrl_t byte_to_ctrl(input logic [7:0] b);
    wdt_ctrl_t c;
    c.hold     = b[B_HOLD];
    c.edge_sel = b[B_EDGE];
    c.pin_en   = b[B_PEN];
    c.itv_mode = b[B_MODE];
    c.clk_sel  = b[B_CSEL];
    c.isel     = b[1:0];
    return c;
  endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter logic [KEY_W-1:0] WR_KEY = 8'h5A
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output wdt_ctrl_t        ctrl_q,
  output logic             clr_now,
  output logic             bad_key
);

  logic key_ok;

  always_comb begin
    key_ok  = (wdata[REG_W-1 -: KEY_W] == WR_KEY);
    bad_key = wr_en && !key_ok;
    clr_now = wr_en && key_ok && wdata[B_CLR];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && key_ok) begin
      ctrl_q <= byte_to_ctrl(wdata[7:0]);
    end
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CW  = 16,
  parameter int TC0 = 32768,
  parameter int TC1 = 8192,
  parameter int TC2 = 512,
  parameter int TC3 = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clr,
  input  logic [1:0]    isel,
  output logic [CW-1:0] cnt_q,
  output logic          expire
);

  logic [CW-1:0] last;

  always_comb begin
    unique case (isel)
      2'd0:    last = CW'(TC0 - 1);
      2'd1:    last = CW'(TC1 - 1);
      2'd2:    last = CW'(TC2 - 1);
      default: last = CW'(TC3 - 1);
    endcase
    expire = run && !clr && (cnt_q >= last);
  end

  always_ff @(posedge clk) begin
    if (rst || clr || expire) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_event.sv
module wdt_event (
  input  logic clk,
  input  logic rst,
  input  logic bad_key,
  input  logic expire,
  input  logic itv_mode,
  output logic rst_req,
  output logic ivl_tick
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req  <= 1'b0;
      ivl_tick <= 1'b0;
    end else begin
      rst_req  <= bad_key || (expire && !itv_mode);
      ivl_tick <= expire && itv_mode;
    end
  end

endmodule

// File: rtl/pwd_watchdog.sv
module pwd_watchdog
  import wdt_pkg::*;
#(
  parameter int               CW     = 16,
  parameter logic [KEY_W-1:0] WR_KEY = 8'h5A,
  parameter logic [KEY_W-1:0] RD_KEY = 8'h69,
  parameter int               TC0    = 32768,
  parameter int               TC1    = 8192,
  parameter int               TC2    = 512,
  parameter int               TC3    = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        rst_req,
  output logic        ivl_tick
);

  wdt_ctrl_t     ctrl_q;
  logic          clr_now;
  logic          bad_key;
  logic          expire;
  logic [CW-1:0] cnt_q;
  logic          wr_en;
  logic          rd_en;

  assign wr_en = bus_sel && bus_we;
  assign rd_en = bus_sel && !bus_we;

  wdt_ctrl_reg #(.WR_KEY(WR_KEY)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wdata   (bus_wdata),
    .ctrl_q  (ctrl_q),
    .clr_now (clr_now),
    .bad_key (bad_key)
  );

  wdt_counter #(
    .CW(CW), .TC0(TC0), .TC1(TC1), .TC2(TC2), .TC3(TC3)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .run    (!ctrl_q.hold),
    .clr    (clr_now),
    .isel   (ctrl_q.isel),
    .cnt_q  (cnt_q),
    .expire (expire)
  );

  wdt_event u_evt (
    .clk      (clk),
    .rst      (rst),
    .bad_key  (bad_key),
    .expire   (expire),
    .itv_mode (ctrl_q.itv_mode),
    .rst_req  (rst_req),
    .ivl_tick (ivl_tick)
  );

  always_ff @(posedge clk) begin
    if (rst || !rd_en) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= {RD_KEY, ctrl_to_byte(ctrl_q)};
    end
  end

endmodule

// File: rtl/pwd_watchdog_chk.sv
module pwd_watchdog_chk #(
  parameter int CW     = 16,
  parameter int TC_MAX = 32768
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [15:0]   bus_wdata,
  input logic [15:0]   bus_rdata,
  input logic          rst_req,
  input logic          ivl_tick,
  input logic [CW-1:0] cnt,
  input logic          hold,
  input logic          itv_mode
);

  logic wr_bad;
  logic wr_good;
  assign wr_bad  = bus_sel && bus_we && (bus_wdata[15:8] != 8'h5A);
  assign wr_good = bus_sel && bus_we && (bus_wdata[15:8] == 8'h5A);

  a_r4_bad_key: assert property (@(posedge clk) disable iff (rst)
    wr_bad |=> rst_req);

  a_r3_read_key: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we) |=> (bus_rdata[15:8] == 8'h69 && !bus_rdata[3]));

  a_r5_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    (hold && !(bus_sel && bus_we)) |=> $stable(cnt));

  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_good && bus_wdata[3]) |=> (cnt == '0));

  a_r8_no_reset_in_itv: assert property (@(posedge clk) disable iff (rst)
    (itv_mode && !wr_bad) |=> !rst_req);

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < TC_MAX);

endmodule

bind pwd_watchdog pwd_watchdog_chk #(.CW(CW), .TC_MAX(TC0)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .rst_req   (rst_req),
  .ivl_tick  (ivl_tick),
  .cnt       (cnt_q),
  .hold      (ctrl_q.hold),
  .itv_mode  (ctrl_q.itv_mode)
);

// File: tb/test_pwd_watchdog.sv
module test_pwd_watchdog;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rst_req;
  logic        ivl_tick;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;

  pwd_watchdog i_pwd_watchdog (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .ivl_tick(ivl_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int          m_cnt;
  logic [7:0]  m_ctrl;
  logic        m_rst, m_itv;
  logic [15:0] m_rd;

  function automatic int term(input logic [1:0] code);
    case (code)
      2'd0: return 32768;
      2'd1: return 8192;
      2'd2: return 512;
      default: return 64;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    cycles  <= cycles + 1;
    if (rst) begin
      m_cnt = 0; m_ctrl = 0; m_rst = 0; m_itv = 0; m_rd = 0;
    end else begin
      bit good, bad, hit;
      good = bus_sel && bus_we && bus_wdata[15:8] == 8'h5A;
      bad  = bus_sel && bus_we && !good;
      hit  = 0;
      m_rd = (bus_sel && !bus_we) ? {8'h69, m_ctrl} : 16'h0;
      if (good && bus_wdata[3]) m_cnt = 0;
      else if (!m_ctrl[7]) begin
        if (m_cnt + 1 >= term(m_ctrl[1:0])) begin hit = 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
      m_rst = bad || (hit && !m_ctrl[4]);
      m_itv = hit && m_ctrl[4];
      if (good) m_ctrl = bus_wdata[7:0] & 8'hF7;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(rst_req == m_rst, "R2/R4/R10 model rst_req", rst_req, m_rst);
      chk(ivl_tick == m_itv, "R8 model ivl_tick", ivl_tick, m_itv);
      chk(bus_rdata == m_rd, "R3/R9 model rdata", bus_rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    if (cycles > WD_LIMIT && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", cycles, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [15:0] d);
    bus_sel = 1; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd(output logic [15:0] v);
    bus_sel = 1; bus_we = 0;
    @(negedge clk);
    bus_sel = 0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // waits until the selected pulse appears; returns the sample index
  task automatic wait_evt(input bit itv, input int max, output int n);
    n = -1;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      if ((itv ? ivl_tick : rst_req) && n < 0) begin n = i; break; end
    end
  endtask

  task automatic do_reset();
    rst = 1;
    idle(2);
    rst = 0;
  endtask

  initial begin
    logic [15:0] v;
    int n;
    bit seen;
    idle(2);
    rst = 0;
    // R2: full default period from reset
    wait_evt(0, 40000, n);
    chk(n == 32768, "R2 first timeout cycle", n, 32768);
    @(negedge clk);
    chk(rst_req == 0, "R10 pulse width one cycle", rst_req, 0);

    do_reset();
    chk(rst_req == 0 && ivl_tick == 0, "R1 outputs after reset", {rst_req, ivl_tick}, 0);
    rd(v);
    chk(v == 16'h6900, "R1 reset control value", v, 16'h6900);
    @(negedge clk);
    chk(bus_rdata == 0, "R3 rdata zero without read", bus_rdata, 0);

    // R9 + R7: stored pin/clock bits, shortest interval, clear
    wr(16'h5A6F);
    wait_evt(0, 100, n);
    chk(n == 64, "R7 code 11 timeout after 64", n, 64);
    rd(v);
    chk(v == 16'h6967, "R9 readback of bits 6,5,2 and clear reads 0", v, 16'h6967);

    // R8: interval mode
    wr(16'h5A1B);
    seen = 0;
    for (int i = 1; i <= 64; i++) begin
      @(negedge clk);
      if (rst_req) seen = 1;
      if (i == 64) chk(ivl_tick == 1, "R8 tick at 64", ivl_tick, 1);
    end
    chk(!seen, "R8 no rst_req in interval mode", seen, 0);
    wait_evt(1, 100, n);
    chk(n == 64, "R8 count restarts after tick", n, 64);

    // R5: hold freezes, release resumes
    wr(16'h5A9B);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (ivl_tick) seen = 1;
    end
    chk(!seen, "R5 no timeout while held", seen, 0);
    wr(16'h5A13);
    wait_evt(1, 100, n);
    chk(n == 64, "R5 resume from held count", n, 64);

    // R4: bad key
    wr(16'h1200);
    chk(rst_req == 1, "R4 bad key raises rst_req", rst_req, 1);
    rd(v);
    chk(v == 16'h6913, "R4 control unchanged after bad key", v, 16'h6913);

    // R6: clear on the edge that would time out
    wr(16'h5A0B);
    idle(63);
    wr(16'h5A0B);
    chk(rst_req == 0, "R6 clear beats timeout", rst_req, 0);
    wait_evt(0, 100, n);
    chk(n == 64, "R6 period restarts from clear", n, 64);

    // R7: shorter code with high count times out at once
    wr(16'h5A08);
    idle(1000);
    wr(16'h5A02);
    @(negedge clk);
    chk(rst_req == 1, "R7 shrink interval below count", rst_req, 1);
    wr(16'h5A09);
    wait_evt(0, 9000, n);
    chk(n == 8192, "R7 code 01 timeout after 8192", n, 8192);
    wr(16'h5A0A);
    wait_evt(0, 600, n);
    chk(n == 512, "R7 code 10 timeout after 512", n, 512);

    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule